// File: doc/BRIEF.md
# Synchronous Burst SRAM

A clocked static memory with a 16-bit word split into two 8-bit byte lanes. Every control input is sampled on the rising clock edge. An access starts when one of two address strobes is asserted and all three chip enables are active. The first strobe serves a processor and the second serves a memory controller. When the processor strobe and the main enable are both active, the processor strobe wins. After that, each clock edge with the block still selected continues the access. It either repeats the current location, or steps a two-bit burst counter through a linear or an exclusive-or ordering.

Three levels of write control decide whether a cycle reads or writes:

- A global write line writes both byte lanes.
- A byte-write gate hands the choice to per-lane write lines.
- When no lane is chosen, the cycle is a read.

A cycle that the processor strobe starts is always a read. A write can follow on the next edge. Read data reaches the output after one register stage in flow-through mode, or after two in pipelined mode. A static input selects the mode. An output-enable input gates the drive flag without waiting for a clock edge. A sleep input stops all activity and deselects the block, and the stored words are kept.

The bidirectional data pins are split into three signals: a write-data input, a read-data output that is zero while not driven, and a drive flag.

Top module: `burst_sram`

## Requirements
- R1: When `ctl_strobe_n` or `cpu_strobe_n` is low at an edge and `en_main_n`=0, `en_hi`=1 and `en_lo_n`=0, the block is selected. `addr_in` becomes the burst base, the burst counter clears, and that edge accesses `addr_in`.
- R2: `cpu_strobe_n` has no effect while `en_main_n`=1. In that case a low `ctl_strobe_n` is still evaluated, and it deselects the block because not all enables are active.
- R3: An edge where an evaluated strobe sees any enable inactive deselects the block. No access happens, and later edges without a strobe perform no access until a new load.
- R4: When `cpu_strobe_n`=0 and `en_main_n`=0, the processor strobe takes priority over `ctl_strobe_n`. That edge is a read whatever the write lines show. A write on the next edge, at the same location, is carried out.
- R5: `wr_all_n`=0 on an accessing edge writes both lanes of `wr_data`. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R6: With `wr_all_n`=1 and `wr_gate_n`=0, each lane whose `lane_wr_n` bit is 0 is written and the other lane is kept. With `lane_wr_n`=2'b11, or with `wr_gate_n`=1, the edge is a read.
- R7: On an edge with no strobe while the block is selected, `adv_n`=0 first increments the 2-bit counter, wrapping from 3 to 0, and `adv_n`=1 keeps it. The accessed address keeps the base's upper bits. Its low two bits are base+count modulo 4 when `xor_order`=0, and base XOR count when `xor_order`=1.
- R8: With `pipe_mode`=0, read data and the drive flag appear right after the reading edge. With `pipe_mode`=1, they appear one edge later.
- R9: `rd_drive` is high only while a read result is valid and `oe_n`=0, and it follows `oe_n` with no clock. `rd_data` is zero whenever `rd_drive` is low.
- R10: While `sleep`=1, no read or write occurs and the block is deselected. The valid read result drops at the edge that samples `sleep`. Stored contents are kept.
- R11: After synchronous reset, the block is deselected and `rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Word address loaded by a strobe |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| en_main_n | input | 1 | Main chip enable, active low |
| en_hi | input | 1 | Second chip enable, active high |
| en_lo_n | input | 1 | Third chip enable, active low |
| adv_n | input | 1 | Burst step request, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_gate_n | input | 1 | Hands write choice to lane lines, active low |
| lane_wr_n | input | 2 | Per-lane write lines, active low |
| wr_data | input | 16 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 = two-stage read, 0 = flow-through |
| xor_order | input | 1 | 1 = XOR burst order, 0 = linear |
| sleep | input | 1 | Low-power hold, active high |
| rd_data | output | 16 | Read data, zero when not driven |
| rd_drive | output | 1 | Read data is being driven |

## Verification
The hardest case to reach from the ports is the interaction of the two strobes with the enables. The bench must produce an edge where the processor strobe is masked but the controller strobe still deselects, and an edge where both strobes fire together with write lines asserted. These edges are built from an already-selected state, so that a wrongly taken path shows up as output that is still driven, or as a changed word later. Burst wrap and XOR ordering need bases whose low bits are nonzero. The bench therefore starts bursts at words 5 and 6 after filling the lower array.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [LANES-1:0] lanes;
    } acc_t;

    // Low address bits of a burst step for either ordering.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               use_xor
    );
        return use_xor ? (start ^ step) : BURST_W'(start + step);
    endfunction

    // Lanes a cycle would write; zero means the cycle reads.
    function automatic logic [LANES-1:0] lane_select(
        input logic             all_n,
        input logic             gate_n,
        input logic [LANES-1:0] per_lane_n
    );
        if (!all_n)  return '1;
        if (!gate_n) return ~per_lane_n;
        return '0;
    endfunction
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              en_main_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              adv_n,
    input  logic              wr_all_n,
    input  logic              wr_gate_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              xor_order,
    input  logic              sleep,
    output acc_t              acc,
    output logic [ADDR_W-1:0] acc_addr
);
    logic               sel_q, sel_nx;
    logic [ADDR_W-1:0]  base_q, base_nx;
    logic [BURST_W-1:0] cnt_q, cnt_nx;
    logic               cpu_go, ctl_go, chips_on;
    logic [LANES-1:0]   lane_req;

    always_comb begin
        cpu_go   = !cpu_strobe_n && !en_main_n;
        ctl_go   = !ctl_strobe_n && !cpu_go;
        chips_on = !en_main_n && en_hi && !en_lo_n;
        lane_req = lane_select(wr_all_n, wr_gate_n, lane_wr_n);
        sel_nx    = sel_q;
        base_nx   = base_q;
        cnt_nx    = cnt_q;
        acc.kind  = ACC_IDLE;
        acc.lanes = '0;
        acc_addr  = base_q;
        if (sleep) begin
            sel_nx = 1'b0;
        end else if (cpu_go || ctl_go) begin
            if (chips_on) begin
                sel_nx   = 1'b1;
                base_nx  = addr_in;
                cnt_nx   = '0;
                acc_addr = addr_in;
                if (ctl_go && |lane_req) begin
                    acc.kind  = ACC_WRITE;
                    acc.lanes = lane_req;
                end else begin
                    acc.kind = ACC_READ;
                end
            end else begin
                sel_nx = 1'b0;
            end
        end else if (sel_q) begin
            if (!adv_n) cnt_nx = BURST_W'(cnt_q + 1'b1);
            acc_addr = {base_q[ADDR_W-1:BURST_W],
                        burst_low(base_q[BURST_W-1:0], cnt_nx, xor_order)};
            if (|lane_req) begin
                acc.kind  = ACC_WRITE;
                acc.lanes = lane_req;
            end else begin
                acc.kind = ACC_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            sel_q  <= sel_nx;
            base_q <= base_nx;
            cnt_q  <= cnt_nx;
        end
    end
endmodule

// File: rtl/bsr_array.sv
module bsr_array
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] s1_word,
    output logic              s1_hit
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (acc.kind == ACC_WRITE && acc.lanes[g])
                bank[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
            if (acc.kind == ACC_READ)
                lane_q <= bank[acc_addr];
        end

        assign s1_word[g*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_hit <= 1'b0;
        else     s1_hit <= (acc.kind == ACC_READ);
    end
endmodule

// File: rtl/bsr_outpipe.sv
module bsr_outpipe
    import bsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              pipe_mode,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] s1_word,
    input  logic              s1_hit,
    output logic              out_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    logic [DATA_W-1:0] s2_word;
    logic              s2_hit;
    logic [DATA_W-1:0] word_sel;

    always_ff @(posedge clk) begin
        if (rst || sleep) s2_hit <= 1'b0;
        else              s2_hit <= s1_hit;
        s2_word <= s1_word;
    end

    always_comb begin
        out_valid = pipe_mode ? s2_hit  : s1_hit;
        word_sel  = pipe_mode ? s2_word : s1_word;
        rd_drive  = out_valid && !oe_n;
        rd_data   = rd_drive ? word_sel : '0;
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              en_main_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              adv_n,
    input  logic              wr_all_n,
    input  logic              wr_gate_n,
    input  logic [1:0]        lane_wr_n,
    input  logic [15:0]       wr_data,
    input  logic              oe_n,
    input  logic              pipe_mode,
    input  logic              xor_order,
    input  logic              sleep,
    output logic [15:0]       rd_data,
    output logic              rd_drive
);
    acc_t              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] s1_word;
    logic              s1_hit;
    logic              out_valid;

    bsr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
        .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n),
        .lane_wr_n(lane_wr_n), .xor_order(xor_order), .sleep(sleep),
        .acc(acc), .acc_addr(acc_addr)
    );

    bsr_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .acc(acc), .acc_addr(acc_addr),
        .wr_data(wr_data), .s1_word(s1_word), .s1_hit(s1_hit)
    );

    bsr_outpipe u_out (
        .clk(clk), .rst(rst), .sleep(sleep), .pipe_mode(pipe_mode),
        .oe_n(oe_n), .s1_word(s1_word), .s1_hit(s1_hit),
        .out_valid(out_valid), .rd_data(rd_data), .rd_drive(rd_drive)
    );
endmodule

// File: rtl/bsr_chk.sv
module bsr_chk
    import bsr_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic sleep,
    input logic cpu_strobe_n,
    input logic ctl_strobe_n,
    input logic en_main_n,
    input logic en_hi,
    input logic en_lo_n,
    input logic wr_all_n,
    input logic oe_n,
    input logic pipe_mode,
    input logic rd_drive,
    input logic out_valid,
    input acc_t acc
);
    // R9
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_drive |-> !oe_n);

    // R10
    sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !out_valid);

    // R10
    sleep_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> acc.kind == ACC_IDLE);

    // R4
    cpu_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe_n && !en_main_n) |-> acc.kind != ACC_WRITE);

    // R5
    all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.kind == ACC_WRITE && !wr_all_n) |-> acc.lanes == '1);

    // R3
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        ((!ctl_strobe_n || (!cpu_strobe_n && !en_main_n)) &&
         !(!en_main_n && en_hi && !en_lo_n) && !pipe_mode)
        |=> (pipe_mode || !out_valid));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);
endmodule

bind burst_sram bsr_chk u_chk (
    .clk(clk), .rst(rst), .sleep(sleep),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
    .wr_all_n(wr_all_n), .oe_n(oe_n), .pipe_mode(pipe_mode),
    .rd_drive(rd_drive), .out_valid(out_valid), .acc(acc)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1;
    logic          en_main_n = 1'b0, en_hi = 1'b1, en_lo_n = 1'b0;
    logic          adv_n = 1'b1, wr_all_n = 1'b1, wr_gate_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic [15:0]   wr_data = '0;
    logic          oe_n = 1'b0, pipe_mode = 1'b0, xor_order = 1'b0, sleep = 1'b0;
    logic [15:0]   rd_data;
    logic          rd_drive;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
        .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n),
        .lane_wr_n(lane_wr_n), .wr_data(wr_data), .oe_n(oe_n),
        .pipe_mode(pipe_mode), .xor_order(xor_order), .sleep(sleep),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    // Behavioural reference model
    logic [15:0] m_mem [64];
    bit          m_sel, m_v1, m_v2, m_acc, m_wr, m_cpu, m_ctl, m_chips;
    logic [15:0] m_d1, m_d2;
    logic [AW-1:0] m_base, m_a;
    int          m_cnt;
    logic [1:0]  m_lanes, m_lo;

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_v1 = 0; m_v2 = 0;
        end else begin
            m_cpu   = !cpu_strobe_n && !en_main_n;
            m_ctl   = !ctl_strobe_n && !m_cpu;
            m_chips = !en_main_n && en_hi && !en_lo_n;
            if (!wr_all_n)       m_lanes = 2'b11;
            else if (!wr_gate_n) m_lanes = ~lane_wr_n;
            else                 m_lanes = 2'b00;
            m_acc = 0; m_wr = 0;
            m_v2 = sleep ? 1'b0 : m_v1;
            m_d2 = m_d1;
            if (sleep) m_sel = 0;
            else if (m_cpu || m_ctl) begin
                if (m_chips) begin
                    m_sel = 1; m_base = addr_in; m_cnt = 0; m_a = addr_in;
                    m_acc = 1; m_wr = m_ctl && (m_lanes != 0);
                end else m_sel = 0;
            end else if (m_sel) begin
                if (!adv_n) m_cnt = (m_cnt + 1) % 4;
                m_lo = xor_order ? (m_base[1:0] ^ 2'(m_cnt)) : 2'(m_base[1:0] + 2'(m_cnt));
                m_a = {m_base[AW-1:2], m_lo};
                m_acc = 1; m_wr = (m_lanes != 0);
            end
            m_v1 = m_acc && !m_wr;
            if (m_v1) m_d1 = m_mem[m_a];
            if (m_acc && m_wr) begin
                if (m_lanes[0]) m_mem[m_a][7:0]  = wr_data[7:0];
                if (m_lanes[1]) m_mem[m_a][15:8] = wr_data[15:8];
            end
        end
    end

    function automatic logic [15:0] pat(input int a);
        return {8'(a + 48), 8'(a ^ 8'hC0)};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model after each edge
    task automatic step();
        bit          ev;
        logic [15:0] ed;
        @(posedge clk);
        @(negedge clk);
        ev = (pipe_mode ? m_v2 : m_v1) && !oe_n;
        ed = ev ? (pipe_mode ? m_d2 : m_d1) : 16'h0;
        chk("R8 model drive", {15'd0, rd_drive}, {15'd0, ev});
        chk("R9 model data", rd_data, ed);
    endtask

    task automatic rest();
        cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1;
        wr_all_n = 1; wr_gate_n = 1; lane_wr_n = 2'b11; sleep = 0;
        en_main_n = 0; en_hi = 1; en_lo_n = 0;
    endtask

    task automatic ld_ctl(input int a, input bit wr, input logic [15:0] d);
        rest(); ctl_strobe_n = 0; addr_in = AW'(a); wr_all_n = !wr; wr_data = d; step();
    endtask

    task automatic ld_cpu(input int a);
        rest(); cpu_strobe_n = 0; addr_in = AW'(a); step();
    endtask

    task automatic nxt(input bit adv);
        rest(); adv_n = !adv; step();
    endtask

    task automatic wr_nxt(input bit adv, input logic [15:0] d);
        rest(); adv_n = !adv; wr_all_n = 0; wr_data = d; step();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        chk("R11 drive after reset", {15'd0, rd_drive}, 16'd0);

        // R5: fill words 0..31 with global writes, linear bursts
        for (int b = 0; b < 32; b += 4) begin
            ld_ctl(b, 1, pat(b));
            for (int k = 1; k < 4; k++) wr_nxt(1, pat(b + k));
        end
        ld_ctl(17, 0, 16'h0);
        chk("R1 ctl load read", rd_data, pat(17));

        // R7 linear order with wrap
        ld_cpu(5);
        chk("R1 cpu load read", rd_data, pat(5));
        nxt(1); chk("R7 linear step1", rd_data, pat(6));
        nxt(1); chk("R7 linear step2", rd_data, pat(7));
        nxt(1); chk("R7 linear wrap", rd_data, pat(4));
        nxt(0); chk("R7 hold on adv high", rd_data, pat(4));

        // R7 xor order from base 6
        xor_order = 1;
        ld_cpu(6); chk("R7 xor base", rd_data, pat(6));
        nxt(1); chk("R7 xor step1", rd_data, pat(7));
        nxt(1); chk("R7 xor step2", rd_data, pat(4));
        nxt(1); chk("R7 xor step3", rd_data, pat(5));
        xor_order = 0;

        // R9 output enable without a clock
        oe_n = 1; #1;
        chk("R9 oe off drive", {15'd0, rd_drive}, 16'd0);
        chk("R9 oe off data", rd_data, 16'h0);
        oe_n = 0; #1;
        chk("R9 oe on drive", {15'd0, rd_drive}, 16'd1);

        // R6 lane writes
        rest(); ctl_strobe_n = 0; addr_in = 20; wr_gate_n = 0; lane_wr_n = 2'b10;
        wr_data = 16'hBEEF; step();
        chk("R6 lane write no drive", {15'd0, rd_drive}, 16'd0);
        ld_cpu(20);
        chk("R6 lane0 only", rd_data, {pat(20)[15:8], 8'hEF});
        rest(); ctl_strobe_n = 0; addr_in = 21; wr_gate_n = 0; lane_wr_n = 2'b11;
        wr_data = 16'h0; step();
        chk("R6 no lane is read", rd_data, pat(21));
        rest(); ctl_strobe_n = 0; addr_in = 23; wr_gate_n = 1; lane_wr_n = 2'b00;
        wr_data = 16'h0; step();
        chk("R6 gate off is read", rd_data, pat(23));

        // R5 global write over a word
        ld_ctl(24, 1, 16'h1234);
        ld_cpu(24); chk("R5 both lanes", rd_data, 16'h1234);

        // R4 both strobes with writes asserted
        rest(); cpu_strobe_n = 0; ctl_strobe_n = 0; addr_in = 22; wr_all_n = 0;
        wr_data = 16'hDEAD; step();
        chk("R4 priority read", rd_data, pat(22));
        nxt(0); chk("R4 word untouched", rd_data, pat(22));
        wr_nxt(0, 16'h7777);
        ld_cpu(22); chk("R4 write next cycle", rd_data, 16'h7777);

        // R3 deselect and no resume
        rest(); ctl_strobe_n = 0; en_hi = 0; step();
        chk("R3 deselect", {15'd0, rd_drive}, 16'd0);
        nxt(1); chk("R3 stays off", {15'd0, rd_drive}, 16'd0);

        // R2 masked processor strobe
        rest(); cpu_strobe_n = 0; en_main_n = 1; addr_in = 9; step();
        chk("R2 cpu ignored", {15'd0, rd_drive}, 16'd0);
        ld_cpu(9); chk("R2 reselect", rd_data, pat(9));
        rest(); cpu_strobe_n = 0; ctl_strobe_n = 0; en_main_n = 1; step();
        chk("R2 ctl deselects", {15'd0, rd_drive}, 16'd0);

        // R10 sleep blocks writes and keeps data
        ld_cpu(12); chk("R10 pre sleep", rd_data, pat(12));
        rest(); sleep = 1; ctl_strobe_n = 0; addr_in = 13; wr_all_n = 0; wr_data = 16'h0;
        step();
        chk("R10 drop on sleep", {15'd0, rd_drive}, 16'd0);
        step();
        rest(); step();
        chk("R10 deselected after wake", {15'd0, rd_drive}, 16'd0);
        ld_cpu(13); chk("R10 contents kept", rd_data, pat(13));

        // R8 pipelined timing
        rest(); ctl_strobe_n = 0; en_hi = 0; step();
        pipe_mode = 1;
        step();
        ld_cpu(9);
        chk("R8 pipe not yet", {15'd0, rd_drive}, 16'd0);
        nxt(1); chk("R8 pipe first", rd_data, pat(9));
        nxt(1); chk("R8 pipe second", rd_data, pat(10));
        rest(); sleep = 1; step();
        chk("R10 pipe sleep drop", {15'd0, rd_drive}, 16'd0);
        rest(); step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule